// File: doc/BRIEF.md
# Serial Real-Valued Sphere Decoder

This block finds the maximum-likelihood symbol vector for a real-valued lattice detection problem. It uses a depth-first tree search over an upper-triangular system `R·s ≈ y`. Each tree level is one real dimension, either the in-phase or the quadrature part of one transmitted symbol. A two-antenna, two-channel-use code therefore gives eight levels. The PAM alphabet per level (2, 4 or 8 points, which matches 4-, 16- or 64-QAM) is chosen at run time when a search starts. The tree depth and the data width are elaboration parameters. All values are signed fixed point with 9 fractional bits.

Software or an upstream factorization stage loads the diagonal and upper entries of `R` and the rotated receive vector `y` through a simple write port, then pulses `start`. The search begins at the last dimension and evaluates exactly one tree node per clock cycle. At each level it enters first the PAM point nearest to the interference-cancelled value divided by the diagonal entry, using a few shift-and-subtract divider steps. It then visits the siblings in alternating order around that point, taking the direction from the sign of the rounding error. A node whose accumulated metric exceeds the best full distance found so far is not expanded. When that happens the next node to evaluate is already chosen: it is the next sibling at the current level, or, if the current level is exhausted, the next sibling at the lowest ancestor level that still has one. Each better leaf shrinks the radius. The search starts from an unbounded radius, so the first leaf reached sets the first radius. When the root level has no sibling left, `done` pulses and the best vector and its distance stay on the outputs.

Top module: `sphere_dec`

## Requirements
- R1: After reset `busy` and `done` are low and `best_sym` and `best_dist` are zero.
- R2: A `start` sampled while idle raises `busy` from the next cycle. `busy` falls in the cycle in which `done` is high. `done` is high for exactly one cycle.
- R3: Each reported symbol (level k in `best_sym[4k+3:4k]`, two's complement) is an odd value in [-(M-1), M-1]. M is 2, 4 or 8 for `mod_sel` 0, 1 or 2; the value 3 also selects 8.
- R4: `best_dist` equals the minimum over all alphabet vectors s of D(s) = Σ_k e_k². Here e_k = y_k − Σ_{j≥k} R[k][j]·s_j, computed in integers on the raw 9-fractional-bit codes, so D carries 18 fractional bits.
- R5: `best_dist` equals D of the reported `best_sym`.
- R6: When y = R·s exactly for an alphabet vector s, the block reports that s and a distance of zero.
- R7: The alphabet size is taken from `mod_sel` in the start cycle and applies to every level of that search.
- R8: Writes to `R` or `y` while `busy` is high are ignored, both by the running search and by later ones.
- R9: The search evaluates one node per busy cycle, and no node twice. The number of busy cycles therefore never exceeds Σ_{k=1..NLEV} M^k, and a move toward the leaves always goes down exactly one level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a search when idle |
| mod_sel | input | 2 | Alphabet select: 0 = 2-PAM, 1 = 4-PAM, 2/3 = 8-PAM |
| wr_en | input | 1 | Write strobe for the matrix/vector file |
| wr_is_y | input | 1 | 1 writes y[wr_row], 0 writes R[wr_row][wr_col] |
| wr_row | input | clog2(NLEV) | Row index |
| wr_col | input | clog2(NLEV) | Column index |
| wr_data | input | DW | Signed fixed-point value, 9 fractional bits |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a search |
| best_sym | output | 4·NLEV | Best symbol vector, 4-bit signed value per level |
| best_dist | output | 2·(DW+6+clog2 NLEV)+clog2(NLEV)+1 | Squared distance of the best vector |

## Verification
A wrong next-node choice would skip part of the tree, and a wrong radius would prune a subtree wrongly. Either fault shows up when the search ends, as a `best_dist` above the exhaustive minimum for that problem. A corrupted stored symbol or metric shows up at the same point, as a distance that no longer matches the reported vector. A fault in the walk order that revisits nodes shows up in the busy time, which exceeds the node-count bound. A fault in the start or end control shows up within one cycle on `busy` and `done`. Sweeping every alphabet against an exhaustive model of D catches these faults, both for exact, noise-free inputs and for noisy and clamped ones.

// File: rtl/sd_pkg.sv
`timescale 1ns/1ps
package sd_pkg;
    localparam int SD_IW = 3;   // index bits for up to 8 PAM points
    localparam int SD_NW = 5;   // sibling step counter bits
    localparam int SD_SW = 4;   // signed symbol value bits

    // alphabet size from the mode select
    function automatic logic [SD_IW:0] pam_size(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    // n-th candidate index around centre c, alternating, first step toward dir
    function automatic int cand_idx(input int c, input logic dir, input int n);
        int k;
        logic up;
        if (n == 0) return c;
        k  = (n + 1) / 2;
        up = (n % 2 == 1) ? dir : !dir;
        return up ? c + k : c - k;
    endfunction
endpackage

// File: rtl/sd_center_div.sv
`timescale 1ns/1ps
module sd_center_div #(
    parameter int BW = 24,
    parameter int DW = 16,
    parameter int IW = 3
) (
    input  logic signed [BW-1:0] b_in,
    input  logic signed [DW-1:0] r_in,
    input  logic        [IW:0]   m_in,
    output logic        [IW-1:0] idx_out
);
    localparam int UW = BW + IW + 4;

    logic signed [UW-1:0] u, d, rem;
    logic        [IW-1:0] q;

    // idx = floor((b + M*r) / (2r)), then clamped into the alphabet
    always_comb begin
        u   = UW'(b_in) + UW'(r_in) * UW'($signed({1'b0, m_in}));
        d   = UW'(r_in) <<< 1;
        rem = u;
        q   = '0;
        if (u < 0) begin
            q = '0;
        end else if (u >= (d <<< IW)) begin
            q = '1;
        end else begin
            for (int i = IW - 1; i >= 0; i--) begin
                if (rem >= (d <<< i)) begin
                    rem  = rem - (d <<< i);
                    q[i] = 1'b1;
                end
            end
        end
        if ({1'b0, q} > m_in - 1'b1) idx_out = IW'(m_in - 1'b1);
        else                         idx_out = q;
    end
endmodule

// File: rtl/sd_sib_next.sv
`timescale 1ns/1ps
module sd_sib_next #(
    parameter int IW = 3,
    parameter int NW = 5
) (
    input  logic [IW-1:0] c_in,
    input  logic          dir_in,
    input  logic [NW-1:0] n_in,
    input  logic [IW:0]   m_in,
    output logic          has_next,
    output logic [NW-1:0] n_next
);
    int  i1, i2;
    logic ok1, ok2;

    // once one side leaves the alphabet, the next admissible step is at most two ahead
    always_comb begin
        i1 = sd_pkg::cand_idx(int'(c_in), dir_in, int'(n_in) + 1);
        i2 = sd_pkg::cand_idx(int'(c_in), dir_in, int'(n_in) + 2);
        ok1 = (i1 >= 0) && (i1 < int'(m_in));
        ok2 = (i2 >= 0) && (i2 < int'(m_in));
        has_next = ok1 || ok2;
        n_next   = ok1 ? NW'(int'(n_in) + 1) : NW'(int'(n_in) + 2);
    end
endmodule

// File: rtl/sd_interf.sv
`timescale 1ns/1ps
module sd_interf #(
    parameter int N  = 8,
    parameter int DW = 16,
    parameter int SW = 4,
    parameter int BW = 24
) (
    input  logic signed [DW-1:0] r_in [N][N],
    input  logic signed [DW-1:0] y_in [N],
    input  logic signed [SW-1:0] v_in [N],
    output logic signed [BW-1:0] b_out [N]
);
    // b_k = y_k - sum over j>k of R[k][j]*v_j
    always_comb begin
        for (int k = 0; k < N; k++) begin
            b_out[k] = BW'(y_in[k]);
            for (int j = 0; j < N; j++) begin
                if (j > k) b_out[k] = b_out[k] - BW'(r_in[k][j]) * BW'(v_in[j]);
            end
        end
    end
endmodule

// File: rtl/sphere_dec.sv
`timescale 1ns/1ps
module sphere_dec #(
    parameter int NLEV = 8,
    parameter int DW   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [1:0]                   mod_sel,
    input  logic                         wr_en,
    input  logic                         wr_is_y,
    input  logic [$clog2(NLEV)-1:0]      wr_row,
    input  logic [$clog2(NLEV)-1:0]      wr_col,
    input  logic [DW-1:0]                wr_data,
    output logic                         busy,
    output logic                         done,
    output logic [NLEV*sd_pkg::SD_SW-1:0] best_sym,
    output logic [2*(DW+sd_pkg::SD_SW+$clog2(NLEV)+2)+$clog2(NLEV):0] best_dist
);
    localparam int IW = sd_pkg::SD_IW;
    localparam int NW = sd_pkg::SD_NW;
    localparam int SW = sd_pkg::SD_SW;
    localparam int LW = $clog2(NLEV);
    localparam int BW = DW + SW + LW + 1;
    localparam int EW = BW + 1;
    localparam int TW = 2 * EW;
    localparam int MW = TW + LW + 1;

    typedef struct packed {
        logic                       busy;
        logic                       done;
        logic [LW-1:0]              lvl;
        logic [IW:0]                m;
        logic [NLEV-1:0][IW-1:0]    c;
        logic [NLEV-1:0]            dir;
        logic [NLEV-1:0][NW-1:0]    n;
        logic [NLEV-1:0][SW-1:0]    v;
        logic [NLEV-1:0][BW-1:0]    b;
        logic [NLEV-1:0][MW-1:0]    pm;
        logic [MW-1:0]              best;
        logic [NLEV-1:0][SW-1:0]    bsym;
    } st_t;

    st_t s_q, s_d;

    logic signed [DW-1:0] r_q [NLEV][NLEV];
    logic signed [DW-1:0] y_q [NLEV];

    // matrix / vector file, frozen while a search runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLEV; i++) begin
                y_q[i] <= '0;
                for (int j = 0; j < NLEV; j++) r_q[i][j] <= '0;
            end
        end else if (wr_en && !s_q.busy) begin
            if (wr_is_y) y_q[wr_row]         <= wr_data;
            else         r_q[wr_row][wr_col] <= wr_data;
        end
    end

    // current node evaluation
    logic [IW-1:0]        cur_c;
    logic [NW-1:0]        cur_n;
    int                   cur_idx;
    logic signed [SW-1:0] cur_val;
    logic signed [SW-1:0] vcur [NLEV];
    logic signed [EW-1:0] rv, e;
    logic signed [TW-1:0] sq;
    logic [MW-1:0]        metric;
    logic                 e_nonneg, prune;
    logic [NLEV-1:0]      dir_eff;
    logic [LW-1:0]        tgt;
    logic signed [BW-1:0] bc [NLEV];
    logic signed [BW-1:0] div_b;
    logic signed [DW-1:0] div_r;
    logic [IW:0]          div_m;
    logic [IW-1:0]        div_idx;
    logic [NLEV-1:0]      has_next;
    logic [NW-1:0]        n_next [NLEV];

    always_comb begin
        cur_c    = s_q.c[s_q.lvl];
        cur_n    = s_q.n[s_q.lvl];
        cur_idx  = sd_pkg::cand_idx(int'(cur_c), s_q.dir[s_q.lvl], int'(cur_n));
        cur_val  = SW'(2 * cur_idx - (int'(s_q.m) - 1));
        for (int k = 0; k < NLEV; k++) vcur[k] = $signed(s_q.v[k]);
        vcur[s_q.lvl] = cur_val;
        rv       = EW'(r_q[s_q.lvl][s_q.lvl]) * EW'(cur_val);
        e        = EW'($signed(s_q.b[s_q.lvl])) - rv;
        sq       = TW'(e) * TW'(e);
        metric   = s_q.pm[s_q.lvl] + MW'($unsigned(sq));
        e_nonneg = (e >= 0);
        prune    = (metric > s_q.best);
        for (int k = 0; k < NLEV; k++)
            dir_eff[k] = (k == int'(s_q.lvl) && cur_n == '0) ? e_nonneg : s_q.dir[k];
        tgt   = (s_q.lvl == '0) ? '0 : s_q.lvl - 1'b1;
        div_b = s_q.busy ? bc[tgt] : bc[NLEV-1];
        div_r = s_q.busy ? r_q[tgt][tgt] : r_q[NLEV-1][NLEV-1];
        div_m = s_q.busy ? s_q.m : sd_pkg::pam_size(mod_sel);
    end

    sd_interf #(.N(NLEV), .DW(DW), .SW(SW), .BW(BW)) u_interf (
        .r_in (r_q),
        .y_in (y_q),
        .v_in (vcur),
        .b_out(bc)
    );

    sd_center_div #(.BW(BW), .DW(DW), .IW(IW)) u_div (
        .b_in   (div_b),
        .r_in   (div_r),
        .m_in   (div_m),
        .idx_out(div_idx)
    );

    for (genvar g = 0; g < NLEV; g++) begin : g_sib
        sd_sib_next #(.IW(IW), .NW(NW)) u_sib (
            .c_in    (s_q.c[g]),
            .dir_in  (dir_eff[g]),
            .n_in    (s_q.n[g]),
            .m_in    (s_q.m),
            .has_next(has_next[g]),
            .n_next  (n_next[g])
        );
    end

    // next-state
    logic          found;
    logic [LW-1:0] sel;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        found    = 1'b0;
        sel      = s_q.lvl;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy          = 1'b1;
                s_d.m             = sd_pkg::pam_size(mod_sel);
                s_d.lvl           = LW'(NLEV - 1);
                s_d.best          = '1;
                s_d.pm[NLEV-1]    = '0;
                s_d.b[NLEV-1]     = bc[NLEV-1];
                s_d.c[NLEV-1]     = div_idx;
                s_d.n[NLEV-1]     = '0;
            end
        end else begin
            if (cur_n == '0) s_d.dir[s_q.lvl] = e_nonneg;
            if (!prune && s_q.lvl != '0) begin
                s_d.v[s_q.lvl] = cur_val;
                s_d.lvl        = tgt;
                s_d.b[tgt]     = bc[tgt];
                s_d.pm[tgt]    = metric;
                s_d.c[tgt]     = div_idx;
                s_d.n[tgt]     = '0;
            end else begin
                if (s_q.lvl == '0 && !prune && metric < s_q.best) begin
                    s_d.best = metric;
                    for (int k = 0; k < NLEV; k++) s_d.bsym[k] = vcur[k];
                end
                for (int k = NLEV - 1; k >= 0; k--) begin
                    if (k >= int'(s_q.lvl) && has_next[k]) begin
                        found = 1'b1;
                        sel   = LW'(k);
                    end
                end
                if (found) begin
                    s_d.n[sel] = n_next[sel];
                    s_d.lvl    = sel;
                end else begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign best_sym  = s_q.bsym;
    assign best_dist = s_q.busy ? '0 : s_q.best;

    // R2: done lasts one cycle and never overlaps busy
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !s_q.busy);
    // R3: the node under evaluation always lies inside the alphabet
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (cur_idx >= 0 && cur_idx < int'(s_q.m)));
    // R4: the radius never grows during a search
    p_radius_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy)) |-> (s_q.best <= $past(s_q.best)));
    // R9: descent goes one level at a time
    p_level_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy) && s_q.lvl < $past(s_q.lvl))
            |-> (s_q.lvl == $past(s_q.lvl) - 1'b1));
    // R7: alphabet size is fixed for the whole search
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy)) |-> $stable(s_q.m));
endmodule

// File: tb/test_sphere_dec.sv
`timescale 1ns/1ps
module test_sphere_dec;
    localparam int NL = 4;
    localparam int DW = 16;
    localparam int LW = $clog2(NL);
    localparam int MW = 2 * (DW + 4 + LW + 2) + LW + 1;
    localparam int WD = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mod_sel = 2'd0;
    logic wr_en = 1'b0, wr_is_y = 1'b0;
    logic [LW-1:0] wr_row = '0, wr_col = '0;
    logic [DW-1:0] wr_data = '0;
    logic busy, done;
    logic [NL*4-1:0] best_sym;
    logic [MW-1:0] best_dist;

    always #2.5 clk = ~clk;

    sphere_dec #(.NLEV(NL), .DW(DW)) i_sphere_dec (
        .clk(clk), .rst_n(rst_n), .start(start), .mod_sel(mod_sel),
        .wr_en(wr_en), .wr_is_y(wr_is_y), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .busy(busy), .done(done),
        .best_sym(best_sym), .best_dist(best_dist)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    int R [NL][NL];
    int Y [NL];
    int got_sym [NL];
    longint got_dist;
    int cycles;
    bit timed_out;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint dist_of(input int s [NL]);
        longint acc, e;
        acc = 0;
        for (int k = 0; k < NL; k++) begin
            e = Y[k];
            for (int j = k; j < NL; j++) e = e - longint'(R[k][j]) * s[j];
            acc += e * e;
        end
        return acc;
    endfunction

    function automatic int msize(input int sel);
        return sel == 0 ? 2 : (sel == 1 ? 4 : 8);
    endfunction

    function automatic longint brute(input int m);
        longint best, d;
        int s [NL];
        best = -1;
        for (int a = 0; a < m; a++)
            for (int b = 0; b < m; b++)
                for (int c = 0; c < m; c++)
                    for (int e = 0; e < m; e++) begin
                        s[0] = 2*a-(m-1); s[1] = 2*b-(m-1);
                        s[2] = 2*c-(m-1); s[3] = 2*e-(m-1);
                        d = dist_of(s);
                        if (best < 0 || d < best) best = d;
                    end
        return best;
    endfunction

    task automatic wr(input bit isy, input int row, input int col, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_is_y = isy; wr_row = LW'(row); wr_col = LW'(col);
        wr_data = DW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load();
        for (int k = 0; k < NL; k++) begin
            for (int j = k; j < NL; j++) wr(1'b0, k, j, R[k][j]);
            wr(1'b1, k, 0, Y[k]);
        end
    endtask

    // random problem; y = R*s + noise
    task automatic make(input int m, input int noise, output int s [NL]);
        for (int k = 0; k < NL; k++) begin
            s[k] = 2 * int'($urandom_range(0, m - 1)) - (m - 1);
            for (int j = 0; j < NL; j++) R[k][j] = 0;
            R[k][k] = int'($urandom_range(256, 1279));
            for (int j = k + 1; j < NL; j++) R[k][j] = int'($urandom_range(0, 511)) - 256;
        end
        for (int k = 0; k < NL; k++) begin
            Y[k] = (noise > 0) ? int'($urandom_range(0, 2*noise)) - noise : 0;
            for (int j = k; j < NL; j++) Y[k] += R[k][j] * s[j];
        end
    endtask

    task automatic run(input int sel, input bit poke);
        logic signed [3:0] t;
        bit seen;
        @(negedge clk);
        start = 1'b1; mod_sel = 2'(sel);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
        cycles = 1; seen = 0; timed_out = 0;
        if (poke) begin
            // R8: writes while busy must not land
            wr_en = 1'b1; wr_is_y = 1'b1; wr_row = '0; wr_data = DW'(12345);
            if (busy) cycles++;
            @(negedge clk);
            wr_is_y = 1'b0; wr_col = '0; wr_data = DW'(7);
            if (busy) cycles++;
            if (done) seen = 1;
            @(negedge clk);
            wr_en = 1'b0;
            if (busy) cycles++;
            if (done) seen = 1;
        end
        while (!seen && cycles < WD) begin
            @(negedge clk);
            if (busy) cycles++;
            if (done) seen = 1;
        end
        if (!seen) begin
            timed_out = 1;
            chk(1'b0, "R2 search timeout", cycles, 0);
        end else begin
            chk(busy == 1'b0, "R2 busy low with done", longint'(busy), 0);
            got_dist = longint'(best_dist);
            for (int k = 0; k < NL; k++) begin
                t = best_sym[k*4 +: 4];
                got_sym[k] = int'(t);
            end
            @(negedge clk);
            chk(done == 1'b0, "R2 done single cycle", longint'(done), 0);
        end
    endtask

    task automatic verify(input int sel, input string tag);
        int m;
        longint exp_d, total;
        m = msize(sel);
        exp_d = brute(m);
        chk(got_dist == exp_d, {"R4 minimum distance ", tag}, got_dist, exp_d);
        chk(dist_of(got_sym) == got_dist, {"R5 distance of vector ", tag}, dist_of(got_sym), got_dist);
        for (int k = 0; k < NL; k++)
            chk((got_sym[k] % 2 != 0) && got_sym[k] <= m - 1 && got_sym[k] >= -(m - 1),
                {"R3 R7 symbol in alphabet ", tag}, got_sym[k], m - 1);
        total = 0;
        for (int k = 1; k <= NL; k++) total += longint'(m) ** k;
        chk(cycles <= total, {"R9 cycle bound ", tag}, cycles, total);
    endtask

    initial begin
        int s [NL];
        longint keep_d;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1 busy", longint'(busy), 0);
        chk(done == 0, "R1 done", longint'(done), 0);
        chk(best_dist == '0, "R1 best_dist", longint'(best_dist), 0);
        chk(best_sym == '0, "R1 best_sym", longint'(best_sym), 0);
        rst_n = 1'b1;
        // R6: exact inputs, every alphabet
        for (int sel = 0; sel < 3; sel++)
            for (int r = 0; r < 3; r++) begin
                make(msize(sel), 0, s);
                load();
                run(sel, 0);
                chk(got_dist == 0, "R6 zero distance", got_dist, 0);
                for (int k = 0; k < NL; k++)
                    chk(got_sym[k] == s[k], "R6 exact vector", got_sym[k], s[k]);
                verify(sel, "exact");
            end
        // noisy sweeps; R7 the same problem under each mode
        for (int r = 0; r < 5; r++) begin
            make(4, 400 + 150 * r, s);
            load();
            for (int sel = 0; sel < 4; sel++) begin
                run(sel, 0);
                verify(sel, "noisy");
            end
        end
        // clamped centres: y far outside the constellation
        make(8, 0, s);
        for (int k = 0; k < NL; k++) Y[k] = (k % 2 == 0) ? 30000 : -30000;
        load();
        run(2, 0);
        verify(2, "clamp");
        run(1, 0);
        verify(1, "clamp");
        // R8: writes during the search are dropped
        make(4, 600, s);
        load();
        run(1, 1);
        verify(1, "R8 during");
        keep_d = got_dist;
        run(1, 0);
        verify(1, "R8 after");
        chk(got_dist == keep_d, "R8 file unchanged", got_dist, keep_d);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule